// File: doc/BRIEF.md
# BCD Calendar Timekeeper With Alarm

This block keeps a time of day and a calendar that step forward by one second at a time. The second is derived from a slow reference tick of nominally 32 kHz: a prescaler counts `SLOW_PER_SEC` of these ticks per second. Each second opens an update window that lasts `UIP_TICKS` further slow ticks. An update-in-progress bit is raised while the window is open. The visible time fields are refreshed only when the window closes, so a reader that sees the bit low knows the fields will not move for the rest of the second.

Internally the time is held in binary. The visible fields are formatted from a snapshot on the fly, so the mode pins take effect at once. A mode pin selects binary or BCD. Another selects 24-hour or 12-hour presentation; in 12-hour mode bit 7 of the hour byte marks PM. A load strobe writes a complete time and date, interpreted in the current format. The load also restarts the second phase.

When the window closes, three alarm bytes for seconds, minutes and hours are compared with the counted time. Any of the three may be a wildcard. On a match, and on each completed update, the block emits a one-cycle flag pulse in interrupt-flag layout.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the fields show 00:00:00, weekday 0, day 1, month 1 and year 0. `uipBit` is 0 and `flagSet` is 0.
- R2: A `loadStb` pulse makes the fields show the loaded time in the cycle after the strobe. The loaded bytes are decoded in the current format. In 12-hour mode a loaded hour with bit 7 set has 12 added.
- R3: The time advances once every `SLOW_PER_SEC` slow ticks, counted from the last load. The advance happens only when `oscCtl` equals 3'b010. With any other value that second is skipped and `uipBit` does not rise.
- R4: At each advance `uipBit` is set. The visible fields hold their old value until `UIP_TICKS` further slow ticks have passed. At that point the fields take the new time and `uipBit` clears.
- R5: While `holdSet` is high, `uipBit` stays 0 and the visible fields are not refreshed, but counting goes on. The first window that closes after `holdSet` falls shows the counted time.
- R6: `binMode`=1 presents and decodes every field in binary; `binMode`=0 uses two BCD digits (tens in bits 7:4). A change of `binMode` shows on the outputs at once.
- R7: With `hour24`=1 the hour byte holds 0 to 23. With `hour24`=0 it holds the hour mod 12, with bit 7 set for hours 12 to 23.
- R8: Seconds and minutes wrap at 60, hours at 24 and the weekday at 7. The day of the month wraps past the month's length to 1 and steps the month. Month 12 wraps to 1 and steps the year, and the year wraps from 99 to 0.
- R9: February has 29 days when the full year (`CENTURY`*100 plus the two-digit year) is divisible by 4 and either is not divisible by 100 or is divisible by 400.
- R10: With `alarmEn`=1, when a window closes each alarm byte matches if its bits 7:6 are 2'b11, or if its decoded value equals the counted field. The hour alarm is compared in 0 to 23. A full match makes `flagSet` carry bits 7 and 5 (8'hA0) for one cycle.
- R11: With `updEn`=1, every closing window makes `flagSet` carry bits 7 and 4 (8'h90) for one cycle. When an alarm match happens in the same window, the pulse is 8'hB0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slowTick | input | 1 | One-cycle pulse at the slow reference rate |
| oscCtl | input | 3 | Oscillator control; 3'b010 means running |
| holdSet | input | 1 | Freeze the visible fields and suppress the in-progress bit |
| alarmEn | input | 1 | Enable the alarm flag |
| updEn | input | 1 | Enable the update-ended flag |
| binMode | input | 1 | 1 = binary fields, 0 = BCD fields |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarmSec | input | 8 | Seconds alarm byte |
| alarmMin | input | 8 | Minutes alarm byte |
| alarmHour | input | 8 | Hours alarm byte |
| loadStb | input | 1 | Load the values below and restart the second phase |
| loadSec | input | 8 | Seconds to load |
| loadMin | input | 8 | Minutes to load |
| loadHour | input | 8 | Hour to load (bit 7 = PM in 12-hour mode) |
| loadWday | input | 8 | Weekday to load, 0 to 6 |
| loadMday | input | 8 | Day of month to load |
| loadMonth | input | 8 | Month to load, 1 to 12 |
| loadYear | input | 8 | Two-digit year to load |
| outSec | output | 8 | Visible seconds |
| outMin | output | 8 | Visible minutes |
| outHour | output | 8 | Visible hour |
| outWday | output | 8 | Visible weekday |
| outMday | output | 8 | Visible day of month |
| outMonth | output | 8 | Visible month |
| outYear | output | 8 | Visible year |
| uipBit | output | 1 | Update in progress |
| flagSet | output | 8 | One-cycle flag pulse: bit 7 any, bit 5 alarm, bit 4 update ended |

## Verification
Loaded values appear one cycle after the strobe. With a tick on every cycle, `uipBit` rises on the `SLOW_PER_SEC`-th edge after the load. The new time and the flag pulse come `UIP_TICKS` edges after that, and the flag clears on the next edge. The following seconds repeat every `SLOW_PER_SEC` edges. The bench drives inputs and samples outputs on falling edges and counts edges from each load. It checks the in-progress bit one edge early and on time, and it checks the fields both inside the window and after it. Format pins are combinational at the outputs, so their effect is sampled on the next falling edge.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int FIELDS  = 7;
  localparam int FIELD_W = 8;
  localparam int CNT_W   = 7;
  localparam int ALARMS  = 3;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_MDAY = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
  } calStb_t;

  function automatic logic [FIELD_W-1:0] encodeField(input logic [CNT_W-1:0] v, input logic bin);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / CNT_W'(10));
    ones = 4'(v % CNT_W'(10));
    return bin ? {1'b0, v} : {tens, ones};
  endfunction

  function automatic logic [FIELD_W-1:0] decodeField(input logic [FIELD_W-1:0] b, input logic bin);
    return bin ? b : (FIELD_W'(b[7:4]) * FIELD_W'(10) + FIELD_W'(b[3:0]));
  endfunction

  function automatic logic [CNT_W-1:0] daysInMonth(input logic [CNT_W-1:0] mo, input int unsigned yr);
    logic leap;
    leap = (yr % 4 == 0) && ((yr % 100 != 0) || (yr % 400 == 0));
    case (mo)
      CNT_W'(2):                                   return leap ? CNT_W'(29) : CNT_W'(28);
      CNT_W'(4), CNT_W'(6), CNT_W'(9), CNT_W'(11): return CNT_W'(30);
      default:                                     return CNT_W'(31);
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int SLOW_PER_SEC = 32768,
  parameter int UIP_TICKS    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    slowTick,
  input  logic [2:0] oscCtl,
  input  logic    holdSet,
  input  logic    loadStb,
  output calStb_t stb,
  output logic    uipBit
);

  localparam int PW = (SLOW_PER_SEC > 1) ? $clog2(SLOW_PER_SEC) : 1;
  localparam int WW = (UIP_TICKS > 1) ? $clog2(UIP_TICKS) : 1;

  logic [PW-1:0] phaseCnt;
  logic [WW-1:0] winCnt;
  logic          inWin;
  logic          secDone;
  logic          winDone;
  logic          oscOk;

  assign oscOk   = (oscCtl == 3'b010);
  assign secDone = slowTick && (phaseCnt == PW'(SLOW_PER_SEC - 1));
  assign winDone = inWin && slowTick && (winCnt == WW'(UIP_TICKS - 1));

  assign stb.load    = loadStb;
  assign stb.advance = !loadStb && secDone && oscOk;
  assign stb.finish  = !loadStb && winDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      winCnt   <= '0;
      inWin    <= 1'b0;
      uipBit   <= 1'b0;
    end else if (loadStb) begin
      phaseCnt <= '0;
      winCnt   <= '0;
      inWin    <= 1'b0;
      uipBit   <= 1'b0;
    end else begin
      if (slowTick) begin
        phaseCnt <= secDone ? '0 : phaseCnt + PW'(1);
      end
      if (stb.advance) begin
        inWin  <= 1'b1;
        winCnt <= '0;
        uipBit <= !holdSet;
      end else if (inWin && slowTick) begin
        if (winDone) begin
          inWin  <= 1'b0;
          uipBit <= 1'b0;
        end else begin
          winCnt <= winCnt + WW'(1);
        end
      end
      if (holdSet) begin
        uipBit <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int CENTURY = 20
) (
  input  logic clk,
  input  logic rstN,
  input  calStb_t stb,
  input  logic holdSet,
  input  logic alarmEn,
  input  logic updEn,
  input  logic binMode,
  input  logic hour24,
  input  logic [ALARMS-1:0][FIELD_W-1:0] alarmBytes,
  input  logic [FIELDS-1:0][FIELD_W-1:0] loadBytes,
  output logic [FIELDS-1:0][FIELD_W-1:0] fieldOut,
  output logic [FIELD_W-1:0] flagSet
);

  logic [FIELDS-1:0][CNT_W-1:0] cnt;
  logic [FIELDS-1:0][CNT_W-1:0] snap;
  logic [FIELDS-1:0][CNT_W-1:0] nxt;
  logic [FIELDS-1:0][CNT_W-1:0] decLoad;
  logic [CNT_W-1:0]  monthLen;
  logic [ALARMS-1:0] almMatch;
  logic              alarmHit;
  logic [FIELD_W-1:0] hourDec;

  // load decode, hour carries the PM bit in 12-hour mode
  assign hourDec = decodeField({1'b0, loadBytes[IDX_HOUR][6:0]}, binMode)
                 + ((!hour24 && loadBytes[IDX_HOUR][7]) ? FIELD_W'(12) : FIELD_W'(0));

  always_comb begin
    for (int i = 0; i < FIELDS; i++) begin
      decLoad[i] = CNT_W'(decodeField(loadBytes[i], binMode));
    end
    decLoad[IDX_HOUR] = CNT_W'(hourDec);
  end

  assign monthLen = daysInMonth(cnt[IDX_MON], 32'(CENTURY * 100) + 32'(cnt[IDX_YEAR]));

  // one-second carry chain
  always_comb begin
    nxt = cnt;
    if (cnt[IDX_SEC] < CNT_W'(59)) begin
      nxt[IDX_SEC] = cnt[IDX_SEC] + CNT_W'(1);
    end else begin
      nxt[IDX_SEC] = '0;
      if (cnt[IDX_MIN] < CNT_W'(59)) begin
        nxt[IDX_MIN] = cnt[IDX_MIN] + CNT_W'(1);
      end else begin
        nxt[IDX_MIN] = '0;
        if (cnt[IDX_HOUR] < CNT_W'(23)) begin
          nxt[IDX_HOUR] = cnt[IDX_HOUR] + CNT_W'(1);
        end else begin
          nxt[IDX_HOUR] = '0;
          nxt[IDX_WDAY] = (cnt[IDX_WDAY] >= CNT_W'(6)) ? '0 : cnt[IDX_WDAY] + CNT_W'(1);
          if (cnt[IDX_MDAY] < monthLen) begin
            nxt[IDX_MDAY] = cnt[IDX_MDAY] + CNT_W'(1);
          end else begin
            nxt[IDX_MDAY] = CNT_W'(1);
            if (cnt[IDX_MON] >= CNT_W'(12)) begin
              nxt[IDX_MON]  = CNT_W'(1);
              nxt[IDX_YEAR] = (cnt[IDX_YEAR] >= CNT_W'(99)) ? '0 : cnt[IDX_YEAR] + CNT_W'(1);
            end else begin
              nxt[IDX_MON] = cnt[IDX_MON] + CNT_W'(1);
            end
          end
        end
      end
    end
  end

  // alarm comparators: sec, min, hour share index with the counters
  for (genvar a = 0; a < ALARMS; a++) begin : g_alm
    assign almMatch[a] = (alarmBytes[a][7:6] == 2'b11)
                      || (decodeField(alarmBytes[a], binMode) == {1'b0, cnt[a]});
  end
  assign alarmHit = alarmEn && (&almMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt            <= '0;
      cnt[IDX_MDAY]  <= CNT_W'(1);
      cnt[IDX_MON]   <= CNT_W'(1);
      snap           <= '0;
      snap[IDX_MDAY] <= CNT_W'(1);
      snap[IDX_MON]  <= CNT_W'(1);
      flagSet        <= '0;
    end else begin
      flagSet <= '0;
      if (stb.load) begin
        cnt  <= decLoad;
        snap <= decLoad;
      end else begin
        if (stb.advance) begin
          cnt <= nxt;
        end
        if (stb.finish) begin
          if (!holdSet) begin
            snap <= cnt;
          end
          flagSet <= {alarmHit || updEn, 1'b0, alarmHit, updEn, 4'b0000};
        end
      end
    end
  end

  // output formatting
  for (genvar f = 0; f < FIELDS; f++) begin : g_fmt
    if (f == IDX_HOUR) begin : g_hour
      logic             pm;
      logic [CNT_W-1:0] h12;
      logic [FIELD_W-1:0] enc12;
      assign pm    = snap[f] >= CNT_W'(12);
      assign h12   = pm ? snap[f] - CNT_W'(12) : snap[f];
      assign enc12 = encodeField(h12, binMode);
      assign fieldOut[f] = hour24 ? encodeField(snap[f], binMode) : (enc12 | {pm, 7'b0});
    end else begin : g_plain
      assign fieldOut[f] = encodeField(snap[f], binMode);
    end
  end

endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int SLOW_PER_SEC = 32768,
  parameter int UIP_TICKS    = 8,
  parameter int CENTURY      = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic [2:0] oscCtl,
  input  logic       holdSet,
  input  logic       alarmEn,
  input  logic       updEn,
  input  logic       binMode,
  input  logic       hour24,
  input  logic [7:0] alarmSec,
  input  logic [7:0] alarmMin,
  input  logic [7:0] alarmHour,
  input  logic       loadStb,
  input  logic [7:0] loadSec,
  input  logic [7:0] loadMin,
  input  logic [7:0] loadHour,
  input  logic [7:0] loadWday,
  input  logic [7:0] loadMday,
  input  logic [7:0] loadMonth,
  input  logic [7:0] loadYear,
  output logic [7:0] outSec,
  output logic [7:0] outMin,
  output logic [7:0] outHour,
  output logic [7:0] outWday,
  output logic [7:0] outMday,
  output logic [7:0] outMonth,
  output logic [7:0] outYear,
  output logic       uipBit,
  output logic [7:0] flagSet
);

  calStb_t stb;
  logic [FIELDS-1:0][FIELD_W-1:0] loadBytes;
  logic [FIELDS-1:0][FIELD_W-1:0] fieldOut;
  logic [ALARMS-1:0][FIELD_W-1:0] alarmBytes;

  assign loadBytes  = {loadYear, loadMonth, loadMday, loadWday, loadHour, loadMin, loadSec};
  assign alarmBytes = {alarmHour, alarmMin, alarmSec};

  cal_ctrl #(
    .SLOW_PER_SEC(SLOW_PER_SEC),
    .UIP_TICKS   (UIP_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .slowTick(slowTick),
    .oscCtl  (oscCtl),
    .holdSet (holdSet),
    .loadStb (loadStb),
    .stb     (stb),
    .uipBit  (uipBit)
  );

  cal_datapath #(
    .CENTURY(CENTURY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .holdSet   (holdSet),
    .alarmEn   (alarmEn),
    .updEn     (updEn),
    .binMode   (binMode),
    .hour24    (hour24),
    .alarmBytes(alarmBytes),
    .loadBytes (loadBytes),
    .fieldOut  (fieldOut),
    .flagSet   (flagSet)
  );

  assign outSec   = fieldOut[IDX_SEC];
  assign outMin   = fieldOut[IDX_MIN];
  assign outHour  = fieldOut[IDX_HOUR];
  assign outWday  = fieldOut[IDX_WDAY];
  assign outMday  = fieldOut[IDX_MDAY];
  assign outMonth = fieldOut[IDX_MON];
  assign outYear  = fieldOut[IDX_YEAR];

endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] oscCtl,
  input logic       holdSet,
  input logic       alarmEn,
  input logic       updEn,
  input logic       binMode,
  input logic       hour24,
  input logic [7:0] outSec,
  input logic       uipBit,
  input logic [7:0] flagSet
);

  // R3
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uipBit) |-> ($past(oscCtl) == 3'b010));

  // R4
  window_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uipBit && $past(uipBit) && $stable(binMode) && $stable(hour24)) |-> $stable(outSec));

  // R5
  hold_no_uip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdSet) |-> !uipBit);

  // R10
  alarm_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagSet[5] |-> $past(alarmEn));

  // R11
  upd_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagSet[4] |-> $past(updEn));

  // R11
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagSet != 8'h00) |=> (flagSet == 8'h00));

endmodule

bind cal_timekeeper cal_timekeeper_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .oscCtl (oscCtl),
  .holdSet(holdSet),
  .alarmEn(alarmEn),
  .updEn  (updEn),
  .binMode(binMode),
  .hour24 (hour24),
  .outSec (outSec),
  .uipBit (uipBit),
  .flagSet(flagSet)
);

// File: tb/cal_timekeeper_bench.sv
`timescale 1ns/1ps
module cal_timekeeper_bench;

  localparam int SPS = 16;
  localparam int UT  = 4;

  typedef struct packed {
    int yy; int mo; int md; int wd; int h; int m; int s;
  } tm_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic [2:0] oscCtl = 3'b010;
  logic holdSet = 1'b0, alarmEn = 1'b0, updEn = 1'b0, binMode = 1'b0, hour24 = 1'b1;
  logic [7:0] alarmSec = 8'h00, alarmMin = 8'h00, alarmHour = 8'h00;
  logic loadStb = 1'b0;
  logic [7:0] loadSec = 0, loadMin = 0, loadHour = 0, loadWday = 0, loadMday = 0, loadMonth = 0, loadYear = 0;
  logic [7:0] outSec, outMin, outHour, outWday, outMday, outMonth, outYear, flagSet;
  logic uipBit;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  cal_timekeeper #(.SLOW_PER_SEC(SPS), .UIP_TICKS(UT), .CENTURY(20)) u_cal_timekeeper (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .oscCtl(oscCtl), .holdSet(holdSet),
    .alarmEn(alarmEn), .updEn(updEn), .binMode(binMode), .hour24(hour24),
    .alarmSec(alarmSec), .alarmMin(alarmMin), .alarmHour(alarmHour),
    .loadStb(loadStb), .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour),
    .loadWday(loadWday), .loadMday(loadMday), .loadMonth(loadMonth), .loadYear(loadYear),
    .outSec(outSec), .outMin(outMin), .outHour(outHour), .outWday(outWday),
    .outMday(outMday), .outMonth(outMonth), .outYear(outYear),
    .uipBit(uipBit), .flagSet(flagSet)
  );

  function automatic tm_t mkTm(int s, int m, int h, int wd, int md, int mo, int yy);
    tm_t t;
    t.s = s; t.m = m; t.h = h; t.wd = wd; t.md = md; t.mo = mo; t.yy = yy;
    return t;
  endfunction

  function automatic logic [7:0] enc(int v, logic bin);
    if (bin) return 8'(v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] encHour(int h, logic bin, logic h24);
    if (h24) return enc(h, bin);
    return enc(h % 12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int monthDays(int mo, int yy);
    int y;
    logic leap;
    y = 2000 + yy;
    leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t nextSec(tm_t t);
    tm_t n;
    n = t;
    n.s = t.s + 1;
    if (n.s == 60) begin
      n.s = 0; n.m = t.m + 1;
      if (n.m == 60) begin
        n.m = 0; n.h = t.h + 1;
        if (n.h == 24) begin
          n.h = 0;
          n.wd = (t.wd + 1) % 7;
          n.md = t.md + 1;
          if (n.md > monthDays(t.mo, t.yy)) begin
            n.md = 1; n.mo = t.mo + 1;
            if (n.mo > 12) begin
              n.mo = 1; n.yy = (t.yy + 1) % 100;
            end
          end
        end
      end
    end
    return n;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkTime(string tag, tm_t e);
    chk({tag, " sec"},   outSec,   enc(e.s, binMode));
    chk({tag, " min"},   outMin,   enc(e.m, binMode));
    chk({tag, " hour"},  outHour,  encHour(e.h, binMode, hour24));
    chk({tag, " wday"},  outWday,  enc(e.wd, binMode));
    chk({tag, " mday"},  outMday,  enc(e.md, binMode));
    chk({tag, " month"}, outMonth, enc(e.mo, binMode));
    chk({tag, " year"},  outYear,  enc(e.yy, binMode));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // called on a falling edge; returns on the falling edge after the load edge
  task automatic loadTime(tm_t t);
    loadSec   = enc(t.s, binMode);
    loadMin   = enc(t.m, binMode);
    loadHour  = encHour(t.h, binMode, hour24);
    loadWday  = enc(t.wd, binMode);
    loadMday  = enc(t.md, binMode);
    loadMonth = enc(t.mo, binMode);
    loadYear  = enc(t.yy, binMode);
    loadStb   = 1'b1;
    @(negedge clk);
    loadStb   = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    tm_t t;
    tm_t e;
    void'($urandom(32'd4242));
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    checkTime("R1", mkTm(0, 0, 0, 0, 1, 1, 0));
    chk("R1 uip", {7'b0, uipBit}, 8'h00);
    chk("R1 flags", flagSet, 8'h00);

    // R2 load, R3 timing, R4 window, R11 update flag, R8 full rollover
    updEn = 1'b1;
    slowTick = 1'b1;
    t = mkTm(58, 59, 23, 6, 31, 12, 99);
    loadTime(t);
    checkTime("R2 load", t);
    step(SPS - 1);
    chk("R3 no early uip", {7'b0, uipBit}, 8'h00);
    step(1);
    chk("R4 uip set", {7'b0, uipBit}, 8'h01);
    chk("R4 frozen sec", outSec, 8'h58);
    step(UT);
    e = nextSec(t);
    checkTime("R4 refreshed", e);
    chk("R4 uip clear", {7'b0, uipBit}, 8'h00);
    chk("R11 update flag", flagSet, 8'h90);
    step(1);
    chk("R11 pulse end", flagSet, 8'h00);
    step(SPS - 1);
    checkTime("R8 year rollover", mkTm(0, 0, 0, 0, 1, 1, 0));
    updEn = 1'b0;

    // R9 leap rules, R8 month lengths
    t = mkTm(59, 59, 23, 1, 28, 2, 0);
    loadTime(t); step(SPS + UT);
    checkTime("R9 2000 leap", mkTm(0, 0, 0, 2, 29, 2, 0));
    t = mkTm(59, 59, 23, 1, 28, 2, 1);
    loadTime(t); step(SPS + UT);
    checkTime("R9 2001 common", mkTm(0, 0, 0, 2, 1, 3, 1));
    t = mkTm(59, 59, 23, 3, 29, 2, 4);
    loadTime(t); step(SPS + UT);
    checkTime("R9 2004 leap end", mkTm(0, 0, 0, 4, 1, 3, 4));
    t = mkTm(59, 59, 23, 5, 30, 4, 10);
    loadTime(t); step(SPS + UT);
    checkTime("R8 30-day month", mkTm(0, 0, 0, 6, 1, 5, 10));

    // R6 format switch
    binMode = 1'b1;
    loadTime(mkTm(7, 45, 9, 2, 15, 8, 23));
    chk("R6 binary min", outMin, 8'h2D);
    binMode = 1'b0;
    step(1);
    chk("R6 bcd min", outMin, 8'h45);

    // R7 12-hour presentation, R2 PM load
    hour24 = 1'b1;
    loadTime(mkTm(0, 5, 13, 2, 15, 8, 23));
    hour24 = 1'b0;
    step(1);
    chk("R7 pm hour", outHour, 8'h81);
    loadTime(mkTm(0, 5, 15, 2, 15, 8, 23));
    chk("R2 pm load bytes", loadHour, 8'h83);
    hour24 = 1'b1;
    step(1);
    chk("R2 pm adds 12", outHour, 8'h15);
    loadTime(mkTm(0, 0, 12, 2, 15, 8, 23));
    hour24 = 1'b0;
    step(1);
    chk("R7 noon", outHour, 8'h80);
    hour24 = 1'b1;
    loadTime(mkTm(0, 0, 0, 2, 15, 8, 23));
    hour24 = 1'b0;
    step(1);
    chk("R7 midnight", outHour, 8'h00);
    hour24 = 1'b1;

    // R10 alarm with hour wildcard
    alarmEn = 1'b1; updEn = 1'b0;
    alarmSec = 8'h30; alarmMin = 8'h10; alarmHour = 8'hC0;
    loadTime(mkTm(29, 10, 7, 1, 3, 3, 3));
    step(SPS + UT);
    chk("R10 alarm match", flagSet, 8'hA0);
    step(SPS);
    chk("R10 alarm miss", flagSet, 8'h00);
    updEn = 1'b1;
    alarmSec = 8'hC5;
    step(SPS);
    chk("R11 alarm plus update", flagSet, 8'hB0);
    alarmEn = 1'b0; updEn = 1'b0;

    // R5 hold
    holdSet = 1'b1;
    loadTime(mkTm(0, 0, 10, 1, 3, 3, 3));
    step(SPS);
    chk("R5 no uip in hold", {7'b0, uipBit}, 8'h00);
    step(UT);
    chk("R5 frozen in hold", outSec, 8'h00);
    holdSet = 1'b0;
    step(SPS);
    chk("R5 counted through hold", outSec, 8'h02);

    // R3 oscillator gate
    oscCtl = 3'b000;
    loadTime(mkTm(0, 0, 5, 1, 3, 3, 3));
    step(SPS);
    chk("R3 stopped no uip", {7'b0, uipBit}, 8'h00);
    step(UT);
    chk("R3 stopped sec", outSec, 8'h00);
    oscCtl = 3'b010;
    step(SPS);
    chk("R3 restarted sec", outSec, 8'h01);

    // random: R6 R7 R8 R10 R11
    for (int it = 0; it < 40; it++) begin
      logic [7:0] ab [3];
      logic hit;
      logic [7:0] expFlag;
      int tgt [3];
      binMode = 1'($urandom % 2);
      hour24  = 1'($urandom % 2);
      updEn   = 1'($urandom % 2);
      alarmEn = 1'b1;
      t = mkTm($urandom % 60, $urandom % 60, $urandom % 24, $urandom % 7,
               1 + $urandom % 28, 1 + $urandom % 12, $urandom % 100);
      if ($urandom % 4 == 0) begin t.s = 59; t.m = 59; t.h = 23; end
      e = nextSec(t);
      tgt[0] = e.s; tgt[1] = e.m; tgt[2] = e.h;
      hit = 1'b1;
      for (int k = 0; k < 3; k++) begin
        int kind;
        int rv;
        kind = $urandom % 3;
        if (kind == 0) begin
          ab[k] = 8'hC0 | 8'($urandom % 64);
        end else if (kind == 1) begin
          ab[k] = enc(tgt[k], binMode);
        end else begin
          rv = (k == 2) ? $urandom % 24 : $urandom % 60;
          ab[k] = enc(rv, binMode);
          if (rv != tgt[k]) hit = 1'b0;
        end
      end
      alarmSec = ab[0]; alarmMin = ab[1]; alarmHour = ab[2];
      loadTime(t);
      step(SPS + UT);
      checkTime("R8 random step", e);
      expFlag = {hit | updEn, 1'b0, hit, updEn, 4'b0000};
      chk("R10 random alarm", flagSet, expFlag);
    end

    summary();
    $finish;
  end

endmodule